// File: doc/BRIEF.md
# Back-to-Back UART Frame Transmitter

This block turns characters from an external transmit FIFO into asynchronous serial frames. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts 16 pulses of a 16x oversampling enable. The baud-rate generator and the FIFO storage are outside the block. The FIFO offers a show-ahead word and a non-empty flag, and the block answers with a single-cycle pop strobe.

The next character is fetched when the first stop bit of the current frame begins, not when the frame ends. If the FIFO holds data at that point, the shift register is refilled at once. The start bit of the next frame then follows the last stop bit with no idle time. If the FIFO is empty at that point, the frame finishes, the line idles high and the empty flag rises. A loopback control sends the serial stream to a receiver-facing output instead of the pin, and the pin is held high while loopback is on.

Top module: `uart_tx_reload`

## Requirements
- R1: After reset, `txd_o` and `loop_rx_o` are 1, `tx_empty_o` is 1 and `fifo_pop_o` is 0.
- R2: A frame starts with a 0 start bit, sends data bits least significant bit first, and every bit lasts exactly 16 oversampling pulses.
- R3: With `cfg_nine_i`=1 the frame carries data bits 0 to 8. With `cfg_nine_i`=0 it carries bits 0 to 7, and bit 8 of the word is not sent.
- R4: With `cfg_par_en_i`=1, one parity bit follows the data bits. It equals the XOR of the sent data bits when `cfg_par_odd_i`=0, and the inverse of that XOR when `cfg_par_odd_i`=1.
- R5: The frame ends with one high stop bit when `cfg_two_stop_i`=0, or two when it is 1.
- R6: If the FIFO is non-empty on the pulse where the first stop bit begins, one pop is issued on that pulse. The next start bit then begins on the pulse right after the last stop bit, with no idle time.
- R7: If the FIFO is empty on that pulse, no reload happens. The line idles high on the pulse after the last stop bit, even when data arrives during the stop bits, and a new frame begins on the following pulse.
- R8: `tx_empty_o` is 0 from the pulse that loads a character from idle until the end of the last frame that has no reload, and 1 otherwise.
- R9: While idle, a character is popped and its start bit begins on the first oversampling pulse on which `fifo_nempty_i` is 1.
- R10: With `cfg_loop_i`=1 the serial stream appears on `loop_rx_o` and `txd_o` stays 1. With `cfg_loop_i`=0 the stream appears on `txd_o` and `loop_rx_o` stays 1.
- R11: `fifo_pop_o` is high for only one clock at a time, and only in a cycle where both `tick16_i` and `fifo_nempty_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle enable at 16 times the bit rate |
| cfg_nine_i | input | 1 | 1: nine data bits, 0: eight |
| cfg_par_en_i | input | 1 | Append a parity bit |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop_i | input | 1 | 1: two stop bits, 0: one |
| cfg_loop_i | input | 1 | Route the stream to the receiver side and park the pin high |
| fifo_nempty_i | input | 1 | The FIFO holds at least one character |
| fifo_data_i | input | 9 | Show-ahead word at the head of the FIFO |
| fifo_pop_o | output | 1 | One-cycle request to remove the head word |
| txd_o | output | 1 | Serial line pin |
| loop_rx_o | output | 1 | Serial stream toward the receiver in loopback |
| tx_empty_o | output | 1 | No character is being shifted or waiting in the shift register |

## Verification
A wrong bit counter or a wrong shift register value shows up at the pin within one bit time, as a level sampled on an oversampling pulse that differs from the expected one. A reload decision made on the wrong pulse shows up immediately, as a FIFO read pointer that moves one pulse early or late. A missed reload appears one bit time later, as a spurious idle pulse with `tx_empty_o` high between frames. Loopback routing errors show on the very first start bit, because the pin and the receiver output then disagree with the expected park levels.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int unsigned WORD_W  = 9;
    localparam int unsigned SHIFT_W = WORD_W + 1;
    localparam int unsigned LEN_W   = $clog2(SHIFT_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        tx_state_e            state;
        logic [SHIFT_W-1:0]   shift;
        logic [LEN_W-1:0]     left;
        logic                 extra_stop;
        logic                 reload;
    } seq_t;
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic               nine_i,
    input  logic               par_en_i,
    input  logic               par_odd_i,
    output logic [SHIFT_W-1:0] payload_o,
    output logic [LEN_W-1:0]   len_o
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] kept;
    logic              par;

    always_comb begin
        for (int i = 0; i < int'(WORD_W); i++) begin
            mask[i] = (i < int'(WORD_W) - 1) || nine_i;
        end
        kept = word_i & mask;
        par  = (^kept) ^ par_odd_i;
        payload_o = {1'b0, kept};
        if (par_en_i) begin
            if (nine_i) begin
                payload_o[WORD_W] = par;
            end else begin
                payload_o[WORD_W-1] = par;
            end
        end
        len_o = LEN_W'(WORD_W - 1) + LEN_W'(nine_i) + LEN_W'(par_en_i);
    end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int unsigned OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic bit_end_o
);
    localparam int unsigned CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        bit_end_o = tick_i && !hold_i && (cnt_q == LAST);
        if (hold_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/uart_tx_route.sv
module uart_tx_route (
    input  logic line_i,
    input  logic loop_en_i,
    output logic txd_o,
    output logic loop_o
);
    always_comb begin
        txd_o  = loop_en_i ? 1'b1 : line_i;
        loop_o = loop_en_i ? line_i : 1'b1;
    end
endmodule

// File: rtl/uart_tx_reload.sv
module uart_tx_reload
    import uart_tx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic              cfg_nine_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_two_stop_i,
    input  logic              cfg_loop_i,
    input  logic              fifo_nempty_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              txd_o,
    output logic              loop_rx_o,
    output logic              tx_empty_o
);
    seq_t               seq_d, seq_q;
    logic [SHIFT_W-1:0] payload;
    logic [LEN_W-1:0]   payload_len;
    logic               bit_end;
    logic               line;

    uart_tx_framer framer_i (
        .word_i    (fifo_data_i),
        .nine_i    (cfg_nine_i),
        .par_en_i  (cfg_par_en_i),
        .par_odd_i (cfg_par_odd_i),
        .payload_o (payload),
        .len_o     (payload_len)
    );

    uart_tx_bit_timer #(.OS_RATE(OS_RATE)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16_i),
        .hold_i    (seq_q.state == ST_IDLE),
        .bit_end_o (bit_end)
    );

    always_comb begin
        seq_d      = seq_q;
        fifo_pop_o = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (tick16_i && fifo_nempty_i) begin
                    fifo_pop_o  = 1'b1;
                    seq_d.shift = payload;
                    seq_d.left  = payload_len;
                    seq_d.state = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) seq_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end) begin
                    seq_d.shift = seq_q.shift >> 1;
                    seq_d.left  = seq_q.left - LEN_W'(1);
                    if (seq_q.left == LEN_W'(1)) begin
                        // first stop bit begins: the reload decision
                        seq_d.state      = ST_STOP;
                        seq_d.extra_stop = cfg_two_stop_i;
                        seq_d.reload     = fifo_nempty_i;
                        if (fifo_nempty_i) begin
                            fifo_pop_o  = 1'b1;
                            seq_d.shift = payload;
                            seq_d.left  = payload_len;
                        end
                    end
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (seq_q.extra_stop) begin
                        seq_d.extra_stop = 1'b0;
                    end else if (seq_q.reload) begin
                        seq_d.reload = 1'b0;
                        seq_d.state  = ST_START;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        unique case (seq_q.state)
            ST_START: line = 1'b0;
            ST_DATA:  line = seq_q.shift[0];
            default:  line = 1'b1;
        endcase
        tx_empty_o = (seq_q.state == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, shift: '0, left: '0, extra_stop: 1'b0, reload: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    uart_tx_route route_i (
        .line_i    (line),
        .loop_en_i (cfg_loop_i),
        .txd_o     (txd_o),
        .loop_o    (loop_rx_o)
    );

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (fifo_nempty_i && tick16_i)); // R11
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> !fifo_pop_o); // R11
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16_i |=> $stable(line)); // R2
    AST_PIN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loop_i |-> txd_o); // R10
    AST_RELOAD_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STOP && bit_end && !seq_q.extra_stop && seq_q.reload)
        |=> (seq_q.state == ST_START)); // R6
    AST_EMPTY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty_o) |-> $past(seq_q.state == ST_STOP)); // R7
endmodule

// File: tb/uart_tx_reload_tb.sv
module uart_tx_reload_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic       nine, par_en, par_odd, two_stop, loop_en;
    logic       fifo_nempty;
    logic [8:0] fifo_data;
    logic       fifo_pop;
    logic       txd, loop_rx, tx_empty;
    logic       fifo_clr;
    logic [8:0] mem [0:3];
    int unsigned rd;
    int unsigned wr_n;
    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;

    always #10 clk = ~clk;

    assign fifo_nempty = (rd < wr_n);
    assign fifo_data   = mem[rd[1:0]];

    always @(posedge clk) begin
        if (fifo_clr)      rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    uart_tx_reload dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick16_i       (tick16),
        .cfg_nine_i     (nine),
        .cfg_par_en_i   (par_en),
        .cfg_par_odd_i  (par_odd),
        .cfg_two_stop_i (two_stop),
        .cfg_loop_i     (loop_en),
        .fifo_nempty_i  (fifo_nempty),
        .fifo_data_i    (fifo_data),
        .fifo_pop_o     (fifo_pop),
        .txd_o          (txd),
        .loop_rx_o      (loop_rx),
        .tx_empty_o     (tx_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
    endtask

    // expected line level at offset off inside one frame
    function automatic int frame_bit(logic [8:0] w, int nd, int pe, int po, int len, int off);
        int b;
        logic [8:0] m;
        b = off / 16;
        if (b == 0) return 0;
        if (b <= len) begin
            if (b - 1 < nd) return int'(w[b-1]);
            m = (nd == 9) ? 9'h1FF : 9'h0FF;
            return int'((^(w & m)) ^ po[0]);
        end
        return 1;
    endfunction

    task automatic check_line(int lvl, int lp, string what);
        // R10 routing of the stream versus the parked output
        chk({what, " R2 R3 R4 R5 stream"}, lp ? int'(loop_rx) : int'(txd), lvl);
        chk("R10 parked output", lp ? int'(txd) : int'(loop_rx), 1);
    endtask

    task automatic prep(int cfg, int n, logic [8:0] w0, logic [8:0] w1, logic [8:0] w2);
        @(negedge clk);
        fifo_clr = 1'b1;
        wr_n = 0;
        @(negedge clk);
        fifo_clr = 1'b0;
        nine = cfg[0]; par_en = cfg[1]; par_odd = cfg[2]; two_stop = cfg[3]; loop_en = cfg[4];
        mem[0] = w0; mem[1] = w1; mem[2] = w2; mem[3] = 9'h0;
        wr_n = n;
    endtask

    task automatic run_sweep(int cfg);
        logic [8:0] w [0:2];
        int nd, len, ns, fr, k, off, ex_rd;
        for (int i = 0; i < 3; i++) w[i] = 9'((cfg * 37 + i * 113 + 85) ^ (i * 256));
        prep(cfg, 3, w[0], w[1], w[2]);
        nd  = cfg[0] ? 9 : 8;
        len = nd + cfg[1];
        ns  = cfg[3] ? 2 : 1;
        fr  = 16 * (1 + len + ns);
        for (int s = 0; s < 3 * fr + 8; s++) begin
            step();
            k   = s / fr;
            off = s % fr;
            if (k < 3) begin
                check_line(frame_bit(w[k], nd, int'(cfg[1]), int'(cfg[2]), len, off), int'(cfg[4]), "R9");
                chk("R8 busy flag", int'(tx_empty), 0);
            end else begin
                check_line(1, int'(cfg[4]), "R7");
                chk("R8 idle flag", int'(tx_empty), 1);
            end
            ex_rd = 1;
            for (int j = 1; j < 3; j++) if ((j - 1) * fr + 16 * (1 + len) <= s) ex_rd++;
            chk("R6 R9 R11 pop count", int'(rd), ex_rd);
        end
    endtask

    task automatic run_gap();
        int fr, off;
        logic [8:0] wa, wb;
        wa = 9'h1A5; wb = 9'h03C;
        prep(0, 1, wa, wb, 9'h0);
        fr = 16 * 10;
        for (int s = 0; s < 2 * fr + 10; s++) begin
            step();
            if (s < fr) begin
                check_line(frame_bit(wa, 8, 0, 0, 8, s), 0, "R7");
                chk("R7 busy", int'(tx_empty), 0);
            end else if (s == fr) begin
                check_line(1, 0, "R7 gap");
                chk("R7 gap empty", int'(tx_empty), 1);
            end else if (s <= 2 * fr) begin
                off = s - fr - 1;
                check_line(frame_bit(wb, 8, 0, 0, 8, off), 0, "R7");
                chk("R7 busy", int'(tx_empty), 0);
            end else begin
                chk("R7 final empty", int'(tx_empty), 1);
            end
            chk("R7 R11 pop count", int'(rd), (s <= fr) ? 1 : 2);
            if (s == 16 * 9 + 3) wr_n = 2;   // data arrives after the decision
        end
    endtask

    initial begin
        rst_n = 1'b0; tick16 = 1'b0; fifo_clr = 1'b1; wr_n = 0;
        nine = 0; par_en = 0; par_odd = 0; two_stop = 0; loop_en = 0;
        for (int i = 0; i < 4; i++) mem[i] = 9'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fifo_clr = 1'b0;
        @(negedge clk);
        chk("R1 txd", int'(txd), 1);
        chk("R1 loop_rx", int'(loop_rx), 1);
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 pop", int'(fifo_pop), 0);
        for (int c = 0; c < 32; c++) run_sweep(c);
        run_gap();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule